// File: doc/BRIEF.md
# Cipher Job Length Tracker

This block keeps the byte budget of one cipher job. Software programs a payload byte count, split over a low and a high word, an associated-data (AAD) byte count and a mode class. Writing one particular register then launches the job. Which register does this depends on the mode class. Plain block-cipher modes launch on the high payload word. The combined authenticate-and-encrypt modes (GCM-like and CCM-like) launch on the AAD word, so that both lengths are in place first.

Before launch the block checks the programmed lengths against the limits of the mode class. A configuration that breaks a limit raises an illegal flag and launches nothing. While a job runs, the downstream datapath offers blocks on a valid/ready handshake. Each block carries a byte count and a phase flag that selects AAD or payload. The tracker subtracts each accepted block from the count of its phase. It also reports how many bytes of the next block are valid and whether that block is the last one of its phase. When both counts reach zero it raises done and stops accepting. In plain mode a payload length of zero means an endless stream. Length registers never read back their contents.

Top module: `cipher_len_tracker`

## Requirements
- R1: Register select 0 holds payload bits [31:0] and select 1 holds payload bits [60:32], taken from write data [28:0]. Select 2 holds the AAD count, and select 3 holds the mode class in write data [1:0]: 0 plain, 1 GCM, 2 CCM, 3 reserved.
- R2: In plain mode, a write to select 1 launches the job. `start_pulse` is high for exactly the one cycle after the write edge, `pay_remain` holds the full payload, `aad_remain` is 0 and `blk_ready` is 1. A write to select 2 in plain mode launches nothing.
- R3: In GCM or CCM mode, a write to select 2 launches the job with both counts loaded. A write to select 1 in these modes launches nothing.
- R4: A plain-mode payload of zero is an endless stream. Accepted payload blocks leave `pay_remain` at 0, `blk_vbytes` reads 16, `blk_ready` stays 1 and `job_done` never rises.
- R5: A block is accepted when `blk_valid` and `blk_ready` are both high. Each accepted block lowers the count of its phase (AAD when `blk_is_aad` is 1) by the smaller of `blk_bytes` (values above 16 count as 16) and that count. No count ever wraps below zero.
- R6: In a bounded job, the edge that brings both counts to zero sets `job_done` and clears `blk_ready`. `job_done` then holds until the next launch.
- R7: In GCM or CCM mode, a launch with both the payload and the AAD count at zero is illegal.
- R8: While a job runs, `blk_vbytes` equals min(16, remaining count of the selected phase). `last_blk` is 1 exactly when that remaining count lies in 1..16.
- R9: Each of the following is illegal: a CCM AAD count above 65280, a GCM payload above 2^36−32 bytes, and any launch attempt in reserved mode. An illegal attempt raises `cfg_illegal`, gives no `start_pulse` and leaves the running job's counts and handshake unchanged. Each launch attempt updates `cfg_illegal`, so a legal launch clears it.
- R10: Reads of selects 0, 1 and 2 return zero. A read of select 3 returns the mode class in bits [1:0].

Handshake rule: `blk_ready` depends only on job state, never on `blk_valid`. A block offered while `blk_ready` is low is simply not taken and may be held for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for writes |
| cfg_wdata | input | 32 | Register write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 32 | Read data |
| blk_valid | input | 1 | Downstream offers a block |
| blk_ready | output | 1 | Tracker accepts blocks (job running) |
| blk_bytes | input | 5 | Bytes in the offered block |
| blk_is_aad | input | 1 | Offered block belongs to the AAD phase |
| start_pulse | output | 1 | One-cycle job launch |
| pay_remain | output | 61 | Remaining payload bytes |
| aad_remain | output | 32 | Remaining AAD bytes |
| last_blk | output | 1 | Next block of the selected phase is its last |
| blk_vbytes | output | 5 | Valid bytes in the next block of the selected phase |
| job_done | output | 1 | Bounded job finished |
| cfg_illegal | output | 1 | Last launch attempt was refused |

## Verification
The bench sweeps every plain payload length from 1 to 40 block by block. A tracker that mis-sized the final partial block, or lowered `last_blk` one block early or late, shows up there. It probes each limit exactly at its boundary and one byte past it. An off-by-one comparator would refuse the largest legal GCM payload or CCM AAD count, or accept the first illegal one. It also checks that a refused attempt leaves the running job intact. It launches from the wrong register for each mode class, runs an endless stream for several blocks, and offers oversize and partial blocks. A design that wrapped a count or finished an endless stream would give a nonzero or missing count there.

// File: rtl/clt_pkg.sv
`timescale 1ns/1ps
package clt_pkg;
  typedef enum logic [1:0] {
    MC_PLAIN = 2'd0,
    MC_GCM   = 2'd1,
    MC_CCM   = 2'd2,
    MC_RSVD  = 2'd3
  } mode_cls_e;

  typedef enum logic [1:0] {
    RG_PAY_LO = 2'd0,
    RG_PAY_HI = 2'd1,
    RG_AAD    = 2'd2,
    RG_MODE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/clt_cfg_regs.sv
`timescale 1ns/1ps
module clt_cfg_regs
  import clt_pkg::*;
#(
  parameter int PAY_W = 61,
  parameter int AAD_W = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [DW-1:0]    wdata,
  input  logic [1:0]       rd_sel,
  output logic [DW-1:0]    rd_data,
  output logic             trig,
  output logic [PAY_W-1:0] pay_next,
  output logic [AAD_W-1:0] aad_next,
  output mode_cls_e        mode
);
  localparam int HI_W = PAY_W - DW;

  logic [DW-1:0]   lo_q;
  logic [HI_W-1:0] hi_q;
  logic [AAD_W-1:0] aad_q;
  mode_cls_e       mode_q;

  logic wr_hi, wr_aad;
  assign wr_hi  = we && (sel == RG_PAY_HI);
  assign wr_aad = we && (sel == RG_AAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      aad_q  <= '0;
      mode_q <= MC_PLAIN;
    end else if (we) begin
      case (sel)
        RG_PAY_LO: lo_q   <= wdata;
        RG_PAY_HI: hi_q   <= wdata[HI_W-1:0];
        RG_AAD:    aad_q  <= wdata[AAD_W-1:0];
        default:   mode_q <= mode_cls_e'(wdata[1:0]);
      endcase
    end
  end

  // launch register depends on the mode class; reserved tries both
  always_comb begin
    trig = 1'b0;
    case (mode_q)
      MC_PLAIN:       trig = wr_hi;
      MC_GCM, MC_CCM: trig = wr_aad;
      default:        trig = wr_hi || wr_aad;
    endcase
  end

  assign pay_next = wr_hi  ? {wdata[HI_W-1:0], lo_q} : {hi_q, lo_q};
  assign aad_next = wr_aad ? wdata[AAD_W-1:0]        : aad_q;
  assign mode     = mode_q;

  // lengths never read back
  assign rd_data = (rd_sel == RG_MODE) ? {{(DW-2){1'b0}}, mode_q} : '0;
endmodule

// File: rtl/clt_limit_check.sv
`timescale 1ns/1ps
module clt_limit_check
  import clt_pkg::*;
#(
  parameter int          PAY_W       = 61,
  parameter int          AAD_W       = 32,
  parameter logic [63:0] CCM_AAD_MAX = 64'd65280,
  parameter logic [63:0] GCM_PAY_MAX = (64'd1 << 36) - 64'd32
) (
  input  mode_cls_e        mode,
  input  logic [PAY_W-1:0] pay,
  input  logic [AAD_W-1:0] aad,
  output logic             illegal,
  output logic             unbounded
);
  logic both_zero;
  assign both_zero = (pay == '0) && (aad == '0);

  always_comb begin
    illegal   = 1'b0;
    unbounded = 1'b0;
    case (mode)
      MC_PLAIN: unbounded = (pay == '0);
      MC_GCM:   illegal   = both_zero || (64'(pay) > GCM_PAY_MAX);
      MC_CCM:   illegal   = both_zero || (64'(aad) > CCM_AAD_MAX);
      default:  illegal   = 1'b1;
    endcase
  end
endmodule

// File: rtl/clt_down_counter.sv
`timescale 1ns/1ps
module clt_down_counter #(
  parameter int W  = 61,
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          dec,
  input  logic [BW-1:0] dec_amt,
  output logic [W-1:0]  cnt,
  output logic          zero_nx
);
  logic [W-1:0] amt_w, take;
  assign amt_w = W'(dec_amt);
  assign take  = (amt_w > cnt) ? cnt : amt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - take;
  end

  always_comb begin
    if (load)     zero_nx = (load_val == '0);
    else if (dec) zero_nx = (cnt == take);
    else          zero_nx = (cnt == '0);
  end

  assert_cnt_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/cipher_len_tracker.sv
`timescale 1ns/1ps
module cipher_len_tracker
  import clt_pkg::*;
#(
  parameter int          PAY_W       = 61,
  parameter int          AAD_W       = 32,
  parameter int          DW          = 32,
  parameter int          BLK         = 16,
  parameter logic [63:0] CCM_AAD_MAX = 64'd65280,
  parameter logic [63:0] GCM_PAY_MAX = (64'd1 << 36) - 64'd32,
  parameter int          BW          = $clog2(BLK) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic [1:0]       rd_sel,
  output logic [DW-1:0]    rd_data,
  input  logic             blk_valid,
  output logic             blk_ready,
  input  logic [BW-1:0]    blk_bytes,
  input  logic             blk_is_aad,
  output logic             start_pulse,
  output logic [PAY_W-1:0] pay_remain,
  output logic [AAD_W-1:0] aad_remain,
  output logic             last_blk,
  output logic [BW-1:0]    blk_vbytes,
  output logic             job_done,
  output logic             cfg_illegal
);
  localparam logic [BW-1:0]    BLK_B = BW'(BLK);
  localparam logic [PAY_W-1:0] BLK_P = PAY_W'(BLK);

  logic             trig, chk_illegal, chk_unb, go, fire;
  logic [PAY_W-1:0] pay_next;
  logic [AAD_W-1:0] aad_next, aad_load;
  mode_cls_e        mode;
  logic             pay_zero_nx, aad_zero_nx;
  logic             active_q, done_q, start_q, illegal_q, unb_q;
  logic [BW-1:0]    take_amt;
  logic [PAY_W-1:0] rem;
  logic             endless_phase;

  clt_cfg_regs #(.PAY_W(PAY_W), .AAD_W(AAD_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rd_sel(rd_sel), .rd_data(rd_data), .trig(trig),
    .pay_next(pay_next), .aad_next(aad_next), .mode(mode)
  );

  assign aad_load = (mode == MC_PLAIN) ? '0 : aad_next;

  clt_limit_check #(.PAY_W(PAY_W), .AAD_W(AAD_W),
                    .CCM_AAD_MAX(CCM_AAD_MAX), .GCM_PAY_MAX(GCM_PAY_MAX)) u_chk (
    .mode(mode), .pay(pay_next), .aad(aad_load),
    .illegal(chk_illegal), .unbounded(chk_unb)
  );

  assign go       = trig && !chk_illegal;
  assign fire     = blk_valid && active_q;
  assign take_amt = (blk_bytes > BLK_B) ? BLK_B : blk_bytes;

  clt_down_counter #(.W(PAY_W), .BW(BW)) u_pay_cnt (
    .clk(clk), .rst_n(rst_n), .load(go), .load_val(pay_next),
    .dec(fire && !blk_is_aad && !unb_q), .dec_amt(take_amt),
    .cnt(pay_remain), .zero_nx(pay_zero_nx)
  );

  clt_down_counter #(.W(AAD_W), .BW(BW)) u_aad_cnt (
    .clk(clk), .rst_n(rst_n), .load(go), .load_val(aad_load),
    .dec(fire && blk_is_aad), .dec_amt(take_amt),
    .cnt(aad_remain), .zero_nx(aad_zero_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      done_q    <= 1'b0;
      start_q   <= 1'b0;
      illegal_q <= 1'b0;
      unb_q     <= 1'b0;
    end else begin
      start_q <= go;
      if (trig) illegal_q <= chk_illegal;
      if (go) begin
        active_q <= 1'b1;
        done_q   <= 1'b0;
        unb_q    <= chk_unb;
      end else if (active_q && !unb_q && pay_zero_nx && aad_zero_nx) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assign endless_phase = unb_q && !blk_is_aad;
  assign rem = blk_is_aad ? PAY_W'(aad_remain) : pay_remain;

  always_comb begin
    if (!active_q)          blk_vbytes = '0;
    else if (endless_phase) blk_vbytes = BLK_B;
    else if (rem >= BLK_P)  blk_vbytes = BLK_B;
    else                    blk_vbytes = rem[BW-1:0];
  end

  assign last_blk    = active_q && !endless_phase && (rem != '0) && (rem <= BLK_P);
  assign blk_ready   = active_q;
  assign job_done    = done_q;
  assign start_pulse = start_q;
  assign cfg_illegal = illegal_q;

  assert_start_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (!cfg_illegal && blk_ready));
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |-> !blk_ready);
  assert_endless_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_ready && unb_q && !blk_is_aad) |=> (blk_ready && !job_done));
  assert_vbytes_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ready |-> (blk_vbytes <= BLK_B));
  assert_refused_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && chk_illegal && !blk_valid) |=> ($stable(pay_remain) && $stable(aad_remain)));
endmodule

// File: tb/cipher_len_tracker_tb.sv
`timescale 1ns/1ps
module cipher_len_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        blk_valid = 1'b0;
  logic        blk_ready;
  logic [4:0]  blk_bytes = '0;
  logic        blk_is_aad = 1'b0;
  logic        start_pulse;
  logic [60:0] pay_remain;
  logic [31:0] aad_remain;
  logic        last_blk;
  logic [4:0]  blk_vbytes;
  logic        job_done;
  logic        cfg_illegal;

  int checks = 0;
  int errors = 0;
  logic saw_start;

  always #5 clk = ~clk;

  cipher_len_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_bytes(blk_bytes),
    .blk_is_aad(blk_is_aad), .start_pulse(start_pulse),
    .pay_remain(pay_remain), .aad_remain(aad_remain), .last_blk(last_blk),
    .blk_vbytes(blk_vbytes), .job_done(job_done), .cfg_illegal(cfg_illegal)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    saw_start = start_pulse;
  endtask

  task automatic give(input logic [4:0] n, input logic aad);
    @(negedge clk);
    blk_valid = 1'b1; blk_bytes = n; blk_is_aad = aad;
    @(negedge clk);
    blk_valid = 1'b0; blk_is_aad = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R2 reset start", start_pulse, 0);
    chk("R6 reset ready", blk_ready, 0);
    chk("R6 reset done", job_done, 0);
    chk("R9 reset illegal", cfg_illegal, 0);
    chk("R10 reset mode read", rd_data, 0);

    // R1 R2 R5 R6 R8: sweep of plain lengths, full blocks
    for (int len = 1; len <= 40; len++) begin
      int rem;
      wr(2'd0, len);
      wr(2'd1, 32'd0);
      chk("R2 start pulse", saw_start, 1);
      chk("R2 aad zero", aad_remain, 0);
      @(negedge clk);
      chk("R2 pulse one cycle", start_pulse, 0);
      rem = len;
      while (rem > 0) begin
        chk("R8 vbytes", blk_vbytes, (rem < 16) ? rem : 16);
        chk("R8 last", last_blk, (rem <= 16) ? 1 : 0);
        give(5'd16, 1'b0);
        rem = (rem < 16) ? 0 : rem - 16;
        chk("R5 pay remain", pay_remain, rem);
      end
      chk("R6 done", job_done, 1);
      chk("R6 ready low", blk_ready, 0);
      @(negedge clk);
      chk("R6 done held", job_done, 1);
    end

    // R5 partial and oversize blocks
    wr(2'd0, 32'd10); wr(2'd1, 32'd0);
    give(5'd3, 1'b0);
    chk("R5 partial", pay_remain, 7);
    chk("R8 vbytes partial", blk_vbytes, 7);
    give(5'd31, 1'b0);
    chk("R5 oversize clamp", pay_remain, 0);
    chk("R6 done after clamp", job_done, 1);

    // R2: aad write in plain mode does not launch
    wr(2'd2, 32'd50);
    chk("R2 aad no start", saw_start, 0);
    chk("R2 still done", job_done, 1);

    // R4 endless stream
    wr(2'd0, 32'd0); wr(2'd1, 32'd0);
    chk("R4 start", saw_start, 1);
    for (int i = 0; i < 5; i++) begin
      give(5'd16, 1'b0);
      chk("R4 count stays", pay_remain, 0);
      chk("R4 ready", blk_ready, 1);
      chk("R4 not done", job_done, 0);
      chk("R4 vbytes", blk_vbytes, 16);
    end

    // R3 GCM job
    wr(2'd3, 32'd1);
    rd_sel = 2'd3; #1;
    chk("R10 mode read", rd_data, 1);
    wr(2'd0, 32'd20);
    wr(2'd1, 32'd0);
    chk("R3 hi no start", saw_start, 0);
    wr(2'd2, 32'd5);
    chk("R3 aad start", saw_start, 1);
    chk("R3 pay loaded", pay_remain, 20);
    chk("R3 aad loaded", aad_remain, 5);
    blk_is_aad = 1'b1; #1;
    chk("R8 aad vbytes", blk_vbytes, 5);
    chk("R8 aad last", last_blk, 1);
    give(5'd16, 1'b1);
    chk("R5 aad drained", aad_remain, 0);
    chk("R6 not done yet", job_done, 0);
    give(5'd16, 1'b0);
    chk("R5 pay 4", pay_remain, 4);
    give(5'd16, 1'b0);
    chk("R6 combined done", job_done, 1);

    // R10 length reads are zero
    for (int s = 0; s < 3; s++) begin
      rd_sel = 2'(s); #1;
      chk("R10 length read zero", rd_data, 0);
    end

    // R7 CCM both zero
    wr(2'd3, 32'd2);
    wr(2'd0, 32'd0); wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
    chk("R7 no start", saw_start, 0);
    chk("R7 illegal", cfg_illegal, 1);
    // R9 CCM AAD boundary
    wr(2'd2, 32'd65280);
    chk("R9 ccm max start", saw_start, 1);
    chk("R9 ccm max legal", cfg_illegal, 0);
    chk("R9 ccm aad loaded", aad_remain, 65280);
    wr(2'd2, 32'd65281);
    chk("R9 ccm over no start", saw_start, 0);
    chk("R9 ccm over illegal", cfg_illegal, 1);
    chk("R9 job kept", aad_remain, 65280);
    chk("R9 ready kept", blk_ready, 1);

    // R9 GCM payload boundary
    wr(2'd3, 32'd1);
    wr(2'd0, 32'hFFFF_FFE0); wr(2'd1, 32'hF);
    wr(2'd2, 32'd0);
    chk("R9 gcm max start", saw_start, 1);
    chk("R9 gcm max remain", pay_remain, 64'hF_FFFF_FFE0);
    wr(2'd0, 32'hFFFF_FFE1);
    wr(2'd2, 32'd0);
    chk("R9 gcm over no start", saw_start, 0);
    chk("R9 gcm over illegal", cfg_illegal, 1);
    chk("R9 gcm job kept", pay_remain, 64'hF_FFFF_FFE0);

    // R9 reserved mode
    wr(2'd3, 32'd3);
    wr(2'd0, 32'd8);
    wr(2'd1, 32'd0);
    chk("R9 rsvd no start", saw_start, 0);
    chk("R9 rsvd illegal", cfg_illegal, 1);

    // R1 high word lands in bits [60:32]
    wr(2'd3, 32'd0);
    wr(2'd0, 32'd7);
    wr(2'd1, 32'h1FFF_FFFF);
    chk("R1 full width", pay_remain, {29'h1FFF_FFFF, 32'd7});
    chk("R9 legal clears", cfg_illegal, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule